// File: doc/BRIEF.md
# Predicated Streaming Vector Adder

The block performs one complete vector addition per command. A command gives a vector length and four superword-aligned base addresses: two source vectors, a destination vector and a predicate vector. The engine runs the whole operation without further commands. It streams 64-bit integer elements through one shared 512-bit memory port, eight elements per superword. It adds matching elements with two's-complement wraparound and stores each sum only where the predicate bit for that element is set.

Every group of eight elements is a step. Each step reads source A, then source B, then, on every 64th step, a fresh predicate superword. It then issues the destination write of the previous step's result. While the sums of one step wait in a result register, the reads of the next step already go out. With an always-granting memory, the port therefore stays busy every cycle.

Top module: `mvadd_engine`

## Requirements
- R1: For element i below the length, the destination holds the 64-bit wraparound sum of the two source elements. Element i of any vector sits in superword base + i/8, at bits [64*(i%8)+63 : 64*(i%8)].
- R2: Element i is stored only when bit i%512 of predicate superword ctl_base + i/512 is 1. When that bit is 0, the destination element keeps its old value.
- R3: Elements at or beyond the length are never modified. Byte enable j covers byte j of the write data, and each 8-byte lane is either fully enabled or fully disabled.
- R4: A step whose eight lanes are all disabled (masked or past the length) issues no write request at all.
- R5: A command with length 0 makes no memory access and raises done in the cycle after start is accepted.
- R6: With the grant held high and N = ceil(length/8) > 0, done is high exactly 3N + 2 + ceil(N/64) cycles after the edge that accepts start. Each step takes 3 port cycles, plus 1 on steps that fetch a predicate superword.
- R7: Done is a single-cycle pulse. It follows the acceptance of the final write, or the final step when that step writes nothing. No request is made while done is high.
- R8: After reset and while idle, done and the request are low. A start raised while a command is running is ignored.
- R9: A request and its address and write flag hold steady until granted. Read data is taken from the data bus in the cycle after the grant.
- R10: Within a step the accesses go in a fixed order: source A, source B, predicate (only on steps that are a multiple of 64), then the write of the previous step's result. The last result is written after the final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| cmd_len | input | 16 | Element count (0 to 65535) |
| cmd_src_a | input | 32 | Superword address of source A |
| cmd_src_b | input | 32 | Superword address of source B |
| cmd_dst | input | 32 | Superword address of destination |
| cmd_ctl | input | 32 | Superword address of the predicate vector |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Superword address |
| mem_wdata | output | 512 | Write data |
| mem_be | output | 64 | Byte enables for writes |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 512 | Read data, valid the cycle after a read grant |

## Verification
In the write slot of a step, two things coincide. The write of the previous step's sums goes out, and the last read data of the current step (source B or the predicate word) arrives and is folded into the new result. The bench provokes this collision on every step. It makes it harder with a pseudo-random grant that stalls the write while the returned data must be held, and with lengths past 512 elements so that a predicate fetch lands in the same window. It judges the outcome by comparing the whole destination region, including untouched tail and masked elements, against sums computed independently from the stored patterns, and by the exact completion cycle when the grant is never withheld.

// File: rtl/mvadd_pkg.sv
package mvadd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_A,
        ST_RD_B,
        ST_RD_C,
        ST_WR,
        ST_WR_LAST,
        ST_DONE
    } mv_state_e;

    typedef enum logic [1:0] {
        TAG_NONE,
        TAG_A,
        TAG_B,
        TAG_C
    } mv_tag_e;
endpackage

// File: rtl/mvadd_sw_adder.sv
// Lane-parallel wraparound adder over one superword.
module mvadd_sw_adder #(
    parameter int ELEM_W = 64,
    parameter int LANES  = 8,
    localparam int SW_W  = ELEM_W * LANES
) (
    input  logic [SW_W-1:0] opnd_a,
    input  logic [SW_W-1:0] opnd_b,
    output logic [SW_W-1:0] sum
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sum[l*ELEM_W +: ELEM_W] = opnd_a[l*ELEM_W +: ELEM_W] + opnd_b[l*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/mvadd_lane_mask.sv
// Per-lane write enable from predicate word, step index and vector length.
module mvadd_lane_mask #(
    parameter int ELEM_W  = 64,
    parameter int LANES   = 8,
    parameter int LEN_W   = 16,
    localparam int SW_W   = ELEM_W * LANES,
    localparam int BPL    = ELEM_W / 8,
    localparam int BE_W   = SW_W / 8,
    localparam int LANE_SH = $clog2(LANES),
    localparam int STEP_W = LEN_W - LANE_SH + 1,
    localparam int IDX_W  = $clog2(SW_W),
    localparam int CSEL_W = IDX_W - LANE_SH,
    localparam int EW     = STEP_W + LANE_SH
) (
    input  logic [SW_W-1:0]   pred_word,
    input  logic [STEP_W-1:0] step,
    input  logic [LEN_W-1:0]  vlen,
    output logic [LANES-1:0]  lane_en,
    output logic [BE_W-1:0]   byte_en
);
    logic [EW-1:0] elem_base;
    assign elem_base = {step, {LANE_SH{1'b0}}};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [EW-1:0]    elem_idx;
        logic [IDX_W-1:0] bit_idx;
        logic             in_range;
        assign elem_idx = elem_base + EW'(l);
        assign bit_idx  = {step[CSEL_W-1:0], LANE_SH'(l)};
        assign in_range = elem_idx < EW'(vlen);
        assign lane_en[l] = in_range & pred_word[bit_idx];
        assign byte_en[l*BPL +: BPL] = {BPL{lane_en[l]}};
    end
endmodule

// File: rtl/mvadd_engine.sv
// Memory-to-memory predicated vector adder with overlapped fetch and store.
module mvadd_engine
    import mvadd_pkg::*;
#(
    parameter int AW     = 32,
    parameter int LEN_W  = 16,
    parameter int ELEM_W = 64,
    parameter int LANES  = 8,
    localparam int SW_W   = ELEM_W * LANES,
    localparam int BE_W   = SW_W / 8,
    localparam int LANE_SH = $clog2(LANES),
    localparam int STEP_W = LEN_W - LANE_SH + 1,
    localparam int CSEL_W = $clog2(SW_W) - LANE_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [AW-1:0]    cmd_src_a,
    input  logic [AW-1:0]    cmd_src_b,
    input  logic [AW-1:0]    cmd_dst,
    input  logic [AW-1:0]    cmd_ctl,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [SW_W-1:0]  mem_wdata,
    output logic [BE_W-1:0]  mem_be,
    input  logic             mem_gnt,
    input  logic [SW_W-1:0]  mem_rdata
);
    typedef struct packed {
        mv_state_e         st;
        mv_tag_e           rtag;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] nsteps;
        logic [LEN_W-1:0]  vlen;
        logic [AW-1:0]     base_a;
        logic [AW-1:0]     base_b;
        logic [AW-1:0]     base_d;
        logic [AW-1:0]     base_c;
        logic [SW_W-1:0]   a_sw;
        logic [SW_W-1:0]   b_sw;
        logic [SW_W-1:0]   c_sw;
        logic              pend_vld;
        logic [AW-1:0]     pend_addr;
        logic [SW_W-1:0]   pend_data;
        logic [BE_W-1:0]   pend_be;
    } eng_regs_t;

    eng_regs_t r_q, r_d;

    // Operands seen this cycle: fresh bus data when a read just returned.
    logic [SW_W-1:0]  a_cur, b_cur, c_cur, sum_cur;
    logic [BE_W-1:0]  be_cur;
    logic [LANES-1:0] lane_en_cur;
    logic             need_pred, last_step, pend_live;
    logic [LEN_W:0]   len_round;

    assign a_cur = (r_q.rtag == TAG_A) ? mem_rdata : r_q.a_sw;
    assign b_cur = (r_q.rtag == TAG_B) ? mem_rdata : r_q.b_sw;
    assign c_cur = (r_q.rtag == TAG_C) ? mem_rdata : r_q.c_sw;

    mvadd_sw_adder #(.ELEM_W(ELEM_W), .LANES(LANES)) u_add (
        .opnd_a (a_cur),
        .opnd_b (b_cur),
        .sum    (sum_cur)
    );

    mvadd_lane_mask #(.ELEM_W(ELEM_W), .LANES(LANES), .LEN_W(LEN_W)) u_mask (
        .pred_word (c_cur),
        .step      (r_q.step),
        .vlen      (r_q.vlen),
        .lane_en   (lane_en_cur),
        .byte_en   (be_cur)
    );

    assign need_pred = (r_q.step[CSEL_W-1:0] == '0);
    assign last_step = ((r_q.step + 1'b1) == r_q.nsteps);
    assign pend_live = r_q.pend_vld && (r_q.pend_be != '0);
    assign len_round = {1'b0, cmd_len} + (LEN_W+1)'(LANES - 1);

    always_comb begin
        r_d      = r_q;
        r_d.rtag = TAG_NONE;
        r_d.a_sw = a_cur;
        r_d.b_sw = b_cur;
        r_d.c_sw = c_cur;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.vlen     = cmd_len;
                    r_d.nsteps   = STEP_W'(len_round >> LANE_SH);
                    r_d.base_a   = cmd_src_a;
                    r_d.base_b   = cmd_src_b;
                    r_d.base_d   = cmd_dst;
                    r_d.base_c   = cmd_ctl;
                    r_d.step     = '0;
                    r_d.pend_vld = 1'b0;
                    r_d.st       = (cmd_len == '0) ? ST_DONE : ST_RD_A;
                end
            end
            ST_RD_A: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base_a + AW'(r_q.step);
                if (mem_gnt) begin
                    r_d.rtag = TAG_A;
                    r_d.st   = ST_RD_B;
                end
            end
            ST_RD_B: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base_b + AW'(r_q.step);
                if (mem_gnt) begin
                    r_d.rtag = TAG_B;
                    r_d.st   = need_pred ? ST_RD_C : ST_WR;
                end
            end
            ST_RD_C: begin
                mem_req  = 1'b1;
                mem_addr = r_q.base_c + AW'(r_q.step >> CSEL_W);
                if (mem_gnt) begin
                    r_d.rtag = TAG_C;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (pend_live) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = r_q.pend_addr;
                end
                if (!pend_live || mem_gnt) begin
                    r_d.pend_vld  = 1'b1;
                    r_d.pend_addr = r_q.base_d + AW'(r_q.step);
                    r_d.pend_data = sum_cur;
                    r_d.pend_be   = be_cur;
                    if (last_step) begin
                        r_d.st = ST_WR_LAST;
                    end else begin
                        r_d.step = r_q.step + 1'b1;
                        r_d.st   = ST_RD_A;
                    end
                end
            end
            ST_WR_LAST: begin
                if (pend_live) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = r_q.pend_addr;
                end
                if (!pend_live || mem_gnt) begin
                    r_d.pend_vld = 1'b0;
                    r_d.st       = ST_DONE;
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done      = (r_q.st == ST_DONE);
    assign mem_wdata = r_q.pend_data;
    assign mem_be    = mem_we ? r_q.pend_be : '0;
endmodule

// File: rtl/mvadd_engine_chk.sv
// Protocol checker, bound to the engine.
module mvadd_engine_chk #(
    parameter int AW    = 32,
    parameter int LEN_W = 16,
    parameter int BE_W  = 64,
    parameter int LANES = 8,
    localparam int BPL  = BE_W / LANES
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [LEN_W-1:0] cmd_len,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_gnt,
    input logic [AW-1:0]    mem_addr,
    input logic [BE_W-1:0]  mem_be
);
    logic busy_m;
    logic accept;
    logic lanes_ok;

    assign accept = start && !busy_m;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_m <= 1'b0;
        end else if (accept) begin
            busy_m <= 1'b1;
        end else if (done) begin
            busy_m <= 1'b0;
        end
    end

    always_comb begin
        lanes_ok = 1'b1;
        for (int l = 0; l < LANES; l++) begin
            if (mem_be[l*BPL +: BPL] != '0 && mem_be[l*BPL +: BPL] != '1) begin
                lanes_ok = 1'b0;
            end
        end
    end

    // R5
    zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_len == '0) |=> done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R4
    no_empty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be != '0));

    // R3
    lane_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> lanes_ok);

    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_m |-> !mem_req);
endmodule

bind mvadd_engine mvadd_engine_chk #(
    .AW    (AW),
    .LEN_W (LEN_W),
    .BE_W  (BE_W),
    .LANES (LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_len  (cmd_len),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_be   (mem_be)
);

// File: tb/mvadd_engine_test.sv
`timescale 1ns/1ps
module mvadd_engine_test;
    localparam int BA = 0, BB = 80, BC = 160, BD = 170;
    localparam int NCASE = 9;
    // {length[15:0], predicate mode[1:0], stall[0]}
    localparam logic [18:0] CASES [NCASE] = '{
        {16'd1,   2'd0, 1'b0},
        {16'd8,   2'd1, 1'b0},
        {16'd16,  2'd0, 1'b0},
        {16'd13,  2'd2, 1'b0},
        {16'd600, 2'd2, 1'b0},
        {16'd600, 2'd1, 1'b1},
        {16'd40,  2'd3, 1'b0},
        {16'd521, 2'd0, 1'b1},
        {16'd77,  2'd2, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] cmd_len = '0;
    logic [31:0] cmd_src_a = '0, cmd_src_b = '0, cmd_dst = '0, cmd_ctl = '0;
    logic done, mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr;
    logic [511:0] mem_wdata, mem_rdata;
    logic [63:0] mem_be;

    logic [511:0] mem [256];
    logic tb_we = 1'b0;
    logic [7:0] tb_addr = '0;
    logic [511:0] tb_data = '0;
    logic stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic gnt_r = 1'b1;
    int acc_cnt = 0, wr_cnt = 0;
    logic [7:0] log_addr [16];
    logic log_we [16];
    int tests = 0, fails = 0;

    always #2 clk = ~clk;
    assign mem_gnt = gnt_r;

    mvadd_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b), .cmd_dst(cmd_dst), .cmd_ctl(cmd_ctl),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    always @(negedge clk) begin
        lfsr  <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        gnt_r <= stall_mode ? lfsr[0] : 1'b1;
    end

    always @(posedge clk) begin
        if (tb_we) begin
            mem[tb_addr] <= tb_data;
        end else if (mem_req && mem_gnt) begin
            if (mem_we) begin
                for (int j = 0; j < 64; j++)
                    if (mem_be[j]) mem[mem_addr[7:0]][j*8 +: 8] <= mem_wdata[j*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
            end
        end
        if (mem_req && mem_gnt) begin
            log_addr[acc_cnt[3:0]] <= mem_addr[7:0];
            log_we[acc_cnt[3:0]]   <= mem_we;
            acc_cnt <= acc_cnt + 1;
            if (mem_we) wr_cnt <= wr_cnt + 1;
        end
    end

    function automatic logic [63:0] fa(int i);
        return 64'hFFFF_FFFF_FFFF_FF00 + 64'(i) * 64'h0000_0001_0000_0003;
    endfunction
    function automatic logic [63:0] fb(int i);
        return {16'h8000 ^ 16'(i), 48'h000F_0000_0100} + 64'(i);
    endfunction
    function automatic logic [63:0] fs(int i);
        return 64'hDEAD_BEEF_0000_0000 | 64'(i);
    endfunction
    function automatic logic pbit(int mode, int i);
        case (mode)
            0: return 1'b1;
            1: return i[0];
            2: return (((i * 7) + (i >> 3)) % 3) != 0;
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [511:0] img(int mode, int w);
        logic [511:0] v;
        for (int l = 0; l < 8; l++) begin
            if (w < BB)      v[l*64 +: 64] = fa(w*8 + l);
            else if (w < BC) v[l*64 +: 64] = fb((w-BB)*8 + l);
            else if (w >= BD) v[l*64 +: 64] = fs((w-BD)*8 + l);
        end
        if (w >= BC && w < BD)
            for (int j = 0; j < 512; j++) v[j] = pbit(mode, (w-BC)*512 + j);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_mem(input int mode);
        for (int w = 0; w < 256; w++) begin
            tb_we = 1'b1; tb_addr = 8'(w); tb_data = img(mode, w);
            @(negedge clk);
        end
        tb_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] len, input int inject, output int kd, output int extra);
        cmd_len = len; cmd_src_a = BA; cmd_src_b = BB; cmd_ctl = BC; cmd_dst = BD;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        kd = 0; extra = 0;
        for (int k = 1; k <= 6000; k++) begin
            if (done) begin
                if (kd == 0) kd = k; else extra++;
            end
            if (kd != 0 && k >= kd + 20) break;
            if (k == inject) begin
                start = 1'b1; cmd_len = 16'd8; cmd_dst = 200; cmd_src_a = 5;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        if (kd == 0) chk(1'b0, "R7 per-command watchdog", 0, 1);
    endtask

    task automatic check_mem(input int len, input int mode, input string tag);
        int bad = 0;
        logic [63:0] act0 = '0, exp0 = '0;
        for (int g = 0; g < 76; g++)
            for (int l = 0; l < 8; l++) begin
                int i = g*8 + l;
                logic [63:0] e = (i < len && pbit(mode, i)) ? fa(i) + fb(i) : fs(i);
                if (mem[BD+g][l*64 +: 64] !== e) begin
                    if (bad == 0) begin act0 = mem[BD+g][l*64 +: 64]; exp0 = e; end
                    bad++;
                end
            end
        chk(bad == 0, tag, act0, exp0);
    endtask

    function automatic int exp_writes(int len, int mode);
        int n = 0;
        for (int g = 0; g < (len + 7) / 8; g++) begin
            logic any = 1'b0;
            for (int l = 0; l < 8; l++)
                if (g*8 + l < len && pbit(mode, g*8 + l)) any = 1'b1;
            if (any) n++;
        end
        return n;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int kd, extra, w0, a0, nst, expk;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(done == 1'b0, "R8 done low after reset", 64'(done), 0);
        chk(mem_req == 1'b0, "R8 no request after reset", 64'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int c = 0; c < NCASE; c++) begin
            int len  = int'(CASES[c][18:3]);
            int mode = int'(CASES[c][2:1]);
            stall_mode = 1'b0;
            load_mem(mode);
            stall_mode = CASES[c][0];
            w0 = wr_cnt;
            run(16'(len), 0, kd, extra);
            stall_mode = 1'b0;
            repeat (2) @(negedge clk);
            // R1 R2 R3: sums, predicate gating, untouched tail
            check_mem(len, mode, "R1 R2 R3 destination contents");
            // R4: fully disabled steps issue no write
            chk((wr_cnt - w0) == exp_writes(len, mode), "R4 write count", 64'(wr_cnt - w0), 64'(exp_writes(len, mode)));
            // R7: single done pulse
            chk(extra == 0, "R7 done pulse count", 64'(extra), 0);
            if (!CASES[c][0]) begin
                nst  = (len + 7) / 8;
                expk = 3*nst + 2 + (nst + 63) / 64;
                // R6: completion cycle with no stalls
                chk(kd == expk, "R6 completion cycle", 64'(kd), 64'(expk));
            end
        end

        // R10: access order for a two-step command
        load_mem(0);
        a0 = acc_cnt;
        run(16'd16, 0, kd, extra);
        begin
            logic [7:0] ea [7] = '{8'd0, 8'd80, 8'd160, 8'd1, 8'd81, 8'd170, 8'd171};
            logic       ew [7] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
            int bad = 0;
            for (int q = 0; q < 7; q++)
                if (log_addr[(a0 + q) % 16] !== ea[q] || log_we[(a0 + q) % 16] !== ew[q]) bad++;
            chk(bad == 0 && (acc_cnt - a0) == 7, "R10 access order", 64'(acc_cnt - a0), 7);
        end

        // R5: zero length
        a0 = acc_cnt;
        run(16'd0, 0, kd, extra);
        chk(kd == 1, "R5 zero-length done cycle", 64'(kd), 1);
        chk(acc_cnt == a0, "R5 zero-length accesses", 64'(acc_cnt - a0), 0);

        // R8: start while busy ignored
        load_mem(0);
        run(16'd16, 3, kd, extra);
        repeat (2) @(negedge clk);
        check_mem(16, 0, "R8 busy start left destination intact");
        chk(extra == 0, "R8 no second completion", 64'(extra), 0);

        // R9: stalled grants give the same result
        load_mem(2);
        stall_mode = 1'b1;
        run(16'd45, 0, kd, extra);
        stall_mode = 1'b0;
        repeat (2) @(negedge clk);
        check_mem(45, 2, "R9 result under grant stalls");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule